// File: doc/BRIEF.md
# Multidrop 9-Bit Receive Address Filter

This block sits between a UART deserializer and its receive FIFO and decides, for every received character, whether that character goes on to the FIFO. Each character arrives as eight data bits plus a ninth bit. With the 9-bit feature off, the ninth bit is ordinary parity and every character is passed on unchanged.

With the feature on, the ninth bit marks a character as an address (1) or as data (0). A receive-enable latch, called SM2 here, gates data. While SM2 is set, data characters are dropped and only address characters are examined. The latch can be cleared in two ways:
- by a host strobe, or
- with automatic addressing enabled, by hardware when an address character hits the station address or the broadcast address. Both addresses are built from an address value and a bit mask.

An accepted character appears on the forward port one clock after it is presented.

Top module: `mdrop_addr_filter`

## Requirements
- R1: A synchronous active-high reset leaves `fwd_valid` at 0 and `sm2_state` at 1.
- R2: While `cfg_mode9` is 0, every character is forwarded with all nine bits unchanged. In this mode `sm2_state` is held at 1 and `host_clr` has no effect on it.
- R3: In 9-bit mode, a character with `rx_bit9` = 0 is a data character. While `sm2_state` is 1, a data character is dropped and does not change the latch.
- R4: In 9-bit mode with `sm2_state` at 0, data characters are forwarded.
- R5: In 9-bit mode with `cfg_auto` at 0, every address character (`rx_bit9` = 1) is forwarded and sets `sm2_state` to 1.
- R6: In 9-bit mode, a `host_clr` pulse clears `sm2_state` on the next edge. This takes priority over any latch change requested by a character in the same cycle.
- R7: With `cfg_auto` at 1, an address character that equals `cfg_station` in every bit where `cfg_mask` is 1 is forwarded and clears `sm2_state`.
- R8: With `cfg_auto` at 1, an address character whose bits are all 1 wherever `cfg_mask` is 1 matches the broadcast address (`cfg_station` OR `cfg_mask`). It is forwarded and clears `sm2_state`.
- R9: With `cfg_auto` at 1, an address character that matches neither address is dropped and sets `sm2_state` to 1.
- R10: Bit positions where `cfg_mask` is 0 are ignored in both comparisons.
- R11: A forwarded character appears on `fwd_valid`/`fwd_data`/`fwd_bit9` exactly one clock after `rx_valid`, as a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode9 | input | 1 | 9-bit multidrop mode enable |
| cfg_auto | input | 1 | Hardware address recognition enable |
| cfg_station | input | 8 | Station address value |
| cfg_mask | input | 8 | Address bit-enable mask |
| host_clr | input | 1 | Host strobe clearing the SM2 latch |
| rx_valid | input | 1 | Received character valid |
| rx_data | input | 8 | Received data bits |
| rx_bit9 | input | 1 | Ninth bit: parity, or address/data flag |
| fwd_valid | output | 1 | Character forwarded to the FIFO |
| fwd_data | output | 8 | Forwarded data bits |
| fwd_bit9 | output | 1 | Forwarded ninth bit |
| sm2_state | output | 1 | Current SM2 latch value |

## Verification
A latch that is stuck or set wrongly shows up at the next data character. That character is either dropped when it should pass or passes when it should be dropped, and `sm2_state` shows the wrong value one clock after the event that should have changed it. A faulty comparator shows up as a wrong forward decision on the very address character that exercises it. The directed cases therefore probe:
- masked-off bits,
- broadcast-only hits,
- misses in both latch states, and
- a host clear that collides with an address character.

// File: rtl/mdf_pkg.sv
package mdf_pkg;

    localparam int DATA_W = 8;

    typedef logic [DATA_W-1:0] char_t;

    typedef struct packed {
        char_t data;
        logic  bit9;
    } rx_char_t;

    typedef enum logic [1:0] {
        SM2_KEEP = 2'd0,
        SM2_SET  = 2'd1,
        SM2_CLR  = 2'd2
    } sm2_act_e;

    typedef struct packed {
        logic     pass;
        sm2_act_e act;
    } decision_t;

    // Compare on enabled bit positions only; masked-off bits never disturb a hit.
    function automatic logic masked_eq(char_t a, char_t b, char_t en);
        return ((a ^ b) & en) == '0;
    endfunction

endpackage

// File: rtl/mdf_addr_match.sv
module mdf_addr_match
    import mdf_pkg::*;
(
    input  char_t rx_addr,
    input  char_t station,
    input  char_t mask,
    output logic  hit_own,
    output logic  hit_bcast
);

    char_t bcast_addr;

    always_comb begin
        bcast_addr = station | mask;
        hit_own    = masked_eq(rx_addr, station, mask);
        hit_bcast  = masked_eq(rx_addr, bcast_addr, mask);
    end

    always_comb begin
        if ((mask == '0) && !($isunknown(rx_addr) || $isunknown(station))) begin
            AST_EMPTY_MASK_HITS: assert (hit_own && hit_bcast); // R10
        end
    end

endmodule

// File: rtl/mdf_sm2_ctrl.sv
module mdf_sm2_ctrl
    import mdf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      mode9,
    input  logic      auto_en,
    input  logic      host_clr,
    input  logic      rx_valid,
    input  logic      rx_bit9,
    input  logic      addr_hit,
    output decision_t dec,
    output logic      sm2
);

    always_comb begin
        dec.pass = 1'b0;
        dec.act  = SM2_KEEP;
        if (rx_valid) begin
            if (!mode9) begin
                dec.pass = 1'b1;
            end else if (!rx_bit9) begin
                dec.pass = !sm2;
            end else if (!auto_en) begin
                dec.pass = 1'b1;
                dec.act  = SM2_SET;
            end else if (addr_hit) begin
                dec.pass = 1'b1;
                dec.act  = SM2_CLR;
            end else begin
                dec.act  = SM2_SET;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !mode9) begin
            sm2 <= 1'b1;
        end else if (host_clr) begin
            sm2 <= 1'b0;
        end else begin
            case (dec.act)
                SM2_SET: sm2 <= 1'b1;
                SM2_CLR: sm2 <= 1'b0;
                default: sm2 <= sm2;
            endcase
        end
    end

    AST_RESET_SETS_SM2: assert property (@(posedge clk) rst |=> sm2); // R1
    AST_MODE_OFF_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !mode9 |=> sm2); // R2
    AST_DATA_DROP: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && mode9 && sm2 && !rx_bit9) |-> !dec.pass); // R3
    AST_HOST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (host_clr && mode9) |=> !sm2); // R6
    AST_MISS_REARMS: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && mode9 && auto_en && rx_bit9 && !addr_hit && !host_clr) |=> sm2); // R9

endmodule

// File: rtl/mdrop_addr_filter.sv
module mdrop_addr_filter
    import mdf_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_mode9,
    input  logic         cfg_auto,
    input  logic [W-1:0] cfg_station,
    input  logic [W-1:0] cfg_mask,
    input  logic         host_clr,
    input  logic         rx_valid,
    input  logic [W-1:0] rx_data,
    input  logic         rx_bit9,
    output logic         fwd_valid,
    output logic [W-1:0] fwd_data,
    output logic         fwd_bit9,
    output logic         sm2_state
);

    rx_char_t  in_char;
    rx_char_t  out_char;
    decision_t dec;
    logic      hit_own;
    logic      hit_bcast;
    logic      out_vld;

    assign in_char.data = char_t'(rx_data);
    assign in_char.bit9 = rx_bit9;

    mdf_addr_match u_match (
        .rx_addr   (in_char.data),
        .station   (char_t'(cfg_station)),
        .mask      (char_t'(cfg_mask)),
        .hit_own   (hit_own),
        .hit_bcast (hit_bcast)
    );

    mdf_sm2_ctrl u_sm2 (
        .clk      (clk),
        .rst      (rst),
        .mode9    (cfg_mode9),
        .auto_en  (cfg_auto),
        .host_clr (host_clr),
        .rx_valid (rx_valid),
        .rx_bit9  (rx_bit9),
        .addr_hit (hit_own | hit_bcast),
        .dec      (dec),
        .sm2      (sm2_state)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld  <= 1'b0;
            out_char <= '0;
        end else begin
            out_vld <= dec.pass;
            if (dec.pass) begin
                out_char <= in_char;
            end
        end
    end

    assign fwd_valid = out_vld;
    assign fwd_data  = W'(out_char.data);
    assign fwd_bit9  = out_char.bit9;

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !fwd_valid); // R1
    AST_PLAIN_PASS: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !cfg_mode9) |=> (fwd_valid && fwd_data == $past(rx_data)
                                      && fwd_bit9 == $past(rx_bit9))); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> !fwd_valid); // R11

endmodule

// File: tb/mdrop_addr_filter_test.sv
module mdrop_addr_filter_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_mode9, cfg_auto, host_clr, rx_valid, rx_bit9;
    logic [7:0] cfg_station, cfg_mask, rx_data;
    logic       fwd_valid, fwd_bit9, sm2_state;
    logic [7:0] fwd_data;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    mdrop_addr_filter uut (
        .clk(clk), .rst(rst), .cfg_mode9(cfg_mode9), .cfg_auto(cfg_auto),
        .cfg_station(cfg_station), .cfg_mask(cfg_mask), .host_clr(host_clr),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_bit9(rx_bit9),
        .fwd_valid(fwd_valid), .fwd_data(fwd_data), .fwd_bit9(fwd_bit9),
        .sm2_state(sm2_state)
    );

    task automatic check(string req, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Presents one character, then samples the registered outputs one clock later.
    task automatic send(string req, logic [7:0] d, logic b9, logic pass, logic sm2_exp);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d; rx_bit9 = b9;
        @(negedge clk);
        rx_valid = 1'b0;
        check(req, "fwd_valid", int'(fwd_valid), int'(pass));
        if (pass) begin
            check(req, "fwd_data", int'(fwd_data), int'(d));
            check(req, "fwd_bit9", int'(fwd_bit9), int'(b9));
        end
        check(req, "sm2_state", int'(sm2_state), int'(sm2_exp));
    endtask

    task automatic pulse_clr(string req, logic sm2_exp);
        @(negedge clk);
        host_clr = 1'b1;
        @(negedge clk);
        host_clr = 1'b0;
        check(req, "sm2 after host_clr", int'(sm2_state), int'(sm2_exp));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", "fwd_valid", int'(fwd_valid), 0);
        check("R1", "sm2_state", int'(sm2_state), 1);
        rst = 1'b0;
    endtask

    task automatic t_plain();
        cfg_mode9 = 1'b0; cfg_auto = 1'b0;
        send("R2", 8'hA5, 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        check("R11", "single-cycle pulse", int'(fwd_valid), 0);
        send("R2", 8'h3C, 1'b0, 1'b1, 1'b1);
        pulse_clr("R2", 1'b1);
    endtask

    task automatic t_manual();
        cfg_mode9 = 1'b1; cfg_auto = 1'b0;
        @(negedge clk);
        send("R3", 8'h11, 1'b0, 1'b0, 1'b1);
        send("R5", 8'h80, 1'b1, 1'b1, 1'b1);
        pulse_clr("R6", 1'b0);
        send("R4", 8'h22, 1'b0, 1'b1, 1'b0);
        send("R5", 8'h81, 1'b1, 1'b1, 1'b1);
        send("R3", 8'h23, 1'b0, 1'b0, 1'b1);
        // host clear collides with an address character that requests a set
        @(negedge clk);
        host_clr = 1'b1; rx_valid = 1'b1; rx_data = 8'h90; rx_bit9 = 1'b1;
        @(negedge clk);
        host_clr = 1'b0; rx_valid = 1'b0;
        check("R6", "clear wins", int'(sm2_state), 0);
        check("R5", "addr forwarded", int'(fwd_valid), 1);
    endtask

    task automatic t_auto();
        cfg_mode9 = 1'b1; cfg_auto = 1'b1;
        cfg_station = 8'h35; cfg_mask = 8'h3F;
        send("R9", 8'h34, 1'b1, 1'b0, 1'b1);
        send("R3", 8'h55, 1'b0, 1'b0, 1'b1);
        send("R10", 8'h75, 1'b1, 1'b1, 1'b0);
        send("R4", 8'h66, 1'b0, 1'b1, 1'b0);
        send("R7", 8'h35, 1'b1, 1'b1, 1'b0);
        send("R9", 8'h34, 1'b1, 1'b0, 1'b1);
        send("R3", 8'h67, 1'b0, 1'b0, 1'b1);
        send("R8", 8'hFF, 1'b1, 1'b1, 1'b0);
        send("R4", 8'h68, 1'b0, 1'b1, 1'b0);
        send("R9", 8'hF5 ^ 8'h01, 1'b1, 1'b0, 1'b1);
        send("R8", 8'h7F, 1'b1, 1'b1, 1'b0);
        cfg_mask = 8'h00;
        send("R10", 8'h00, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_mode_off();
        cfg_mode9 = 1'b0;
        @(negedge clk);
        check("R2", "sm2 forced high", int'(sm2_state), 1);
    endtask

    initial begin
        cfg_mode9 = 0; cfg_auto = 0; cfg_station = 0; cfg_mask = 0;
        host_clr = 0; rx_valid = 0; rx_data = 0; rx_bit9 = 0; rst = 1;
        t_reset();
        t_plain();
        t_manual();
        t_auto();
        t_mode_off();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule